// File: doc/BRIEF.md
# Dual-Function Parallel Port Register Block

This block holds the bus-visible registers of an 8-bit parallel port. Each pin can act as plain I/O or carry an alternate function. Software sets two things for each pin: its direction (input or output) and its function (port or alternate). An output latch holds the value that port-function output pins drive.

A data read is built pin by pin. An input pin returns its live, synchronized level. An output pin returns the latch bit. This holds whatever the pin's function, so a pin in use by an alternate function can still be read. Software can also make such a pin toggle: it switches the pin back to port function as an output and writes the latch.

Two read-only addresses return the raw levels of two neighbouring 8-bit ports. A status address returns four handshake pin levels beside four sticky status flags. The latch deliberately survives reset. Writes to read-only addresses are acknowledged and then thrown away.

Top module: `pport_regs`

Address map (`addr`): 0 = direction (1 = output), 1 = function select (1 = alternate), 2 = data / output latch, 3 = neighbour port A level (read-only), 4 = neighbour port B level (read-only), 5 = status. Any other address reads 0.

## Requirements
- R1: After reset the direction register and function-select register read 0, the status flags [3:0] read 0, and `ack` is 0.
- R2: On a data read (address 2), every bit whose direction bit is 0 returns the synchronized `pin_in` level. This holds whether the function bit is 0 or 1.
- R3: On a data read, every bit whose direction bit is 1 returns the output latch bit and not the pin.
- R4: A write to address 2 always loads the output latch, whatever the direction and function settings.
- R5: The output latch keeps its value through an assertion of `rst_n`.
- R6: For each pin, direction 0 gives `pin_oe`=0. Direction 1 with port function gives `pin_oe`=1 and `pin_out`=latch bit. Direction 1 with alternate function gives `pin_oe`=`alt_oe` and `pin_out`=`alt_out`.
- R7: Addresses 3 and 4 return the synchronized `pa_in` and `pb_in` levels. A write to either is acknowledged, but it changes no register.
- R8: Status read bits [7:4] give `hs_in[3:0]` (bit 7 = `hs_in[3]`), synchronized. Bits [3:0] are flags, with 1 meaning asserted. A flag is set by a high `stat_set` bit and stays set until software writes 1 to it at address 5. When a set and a clear fall in the same cycle, the set wins.
- R9: `ack` rises the cycle after each cycle that `sel` is high, for reads and writes alike. `rdata` is valid while `ack` is high and is 0 otherwise. Unmapped addresses read 0.
- R10: Every pin-level input goes through a two-flop synchronizer. A read whose `sel` cycle begins at the same time as a pin change, or one cycle after it, returns the old level. A read issued two cycles after the change returns the new level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Access select, one access per high cycle |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid with ack |
| ack | output | 1 | Transfer acknowledge |
| pin_in | input | 8 | Port pin levels |
| pin_out | output | 8 | Port pin drive value |
| pin_oe | output | 8 | Port pin output enable |
| alt_out | input | 8 | Alternate-function drive value |
| alt_oe | input | 8 | Alternate-function output enable |
| pa_in | input | 8 | Neighbour port A pin levels |
| pb_in | input | 8 | Neighbour port B pin levels |
| hs_in | input | 4 | Handshake pin levels |
| stat_set | input | 4 | Status flag set pulses |

## Verification
Two cases are hard to reach from the ports. The first is proving that the latch survives reset, because the latch can only be read back through pins that reset itself turns into inputs. The stimulus loads the latch and pulses reset. It then sets every pin to output and reads the data address, which exposes the old value.

The second is the synchronizer latency. The stimulus changes `pin_in` in the same cycle that it starts a long read, and keeps `sel` high for three cycles. The expected result is the old level twice, then the new level.

// File: rtl/pport_pkg.sv
package pport_pkg;
  typedef enum logic [2:0] {
    A_DIR  = 3'd0,
    A_FSEL = 3'd1,
    A_DATA = 3'd2,
    A_ALTA = 3'd3,
    A_ALTB = 3'd4,
    A_STAT = 3'd5
  } paddr_e;
endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/pport_pinmux.sv
module pport_pinmux #(
  parameter int W = 8
) (
  input  logic [W-1:0] dir,
  input  logic [W-1:0] fsel,
  input  logic [W-1:0] latch,
  input  logic [W-1:0] alt_out,
  input  logic [W-1:0] alt_oe,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    // alternate function owns both the value and the enable; direction gates the enable
    assign pin_out[i] = fsel[i] ? alt_out[i] : latch[i];
    assign pin_oe[i]  = dir[i] & (fsel[i] ? alt_oe[i] : 1'b1);
  end
endmodule

// File: rtl/pport_rdmux.sv
module pport_rdmux
  import pport_pkg::*;
#(
  parameter int W = 8,
  localparam int H = W / 2
) (
  input  logic [2:0]   addr,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] fsel,
  input  logic [W-1:0] latch,
  input  logic [W-1:0] pin_s,
  input  logic [W-1:0] pa_s,
  input  logic [W-1:0] pb_s,
  input  logic [H-1:0] hs_s,
  input  logic [H-1:0] flags,
  output logic [W-1:0] rd_val
);
  logic [W-1:0] data_view;

  for (genvar i = 0; i < W; i++) begin : g_view
    // input pins are sampled live, output pins reflect the latch
    assign data_view[i] = dir[i] ? latch[i] : pin_s[i];
  end

  always_comb begin
    unique case (addr)
      A_DIR:   rd_val = dir;
      A_FSEL:  rd_val = fsel;
      A_DATA:  rd_val = data_view;
      A_ALTA:  rd_val = pa_s;
      A_ALTB:  rd_val = pb_s;
      A_STAT:  rd_val = {hs_s, flags};
      default: rd_val = '0;
    endcase
  end
endmodule

// File: rtl/pport_regs.sv
module pport_regs
  import pport_pkg::*;
#(
  parameter int W = 8,
  localparam int H = W / 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel,
  input  logic         wr,
  input  logic [2:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         ack,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  input  logic [W-1:0] alt_out,
  input  logic [W-1:0] alt_oe,
  input  logic [W-1:0] pa_in,
  input  logic [W-1:0] pb_in,
  input  logic [H-1:0] hs_in,
  input  logic [H-1:0] stat_set
);
  logic [W-1:0] dir_q, dir_d, fsel_q, fsel_d, latch_q, latch_d;
  logic [H-1:0] flag_q, flag_d;
  logic [W-1:0] rdata_q, rdata_d;
  logic         ack_q, ack_d;
  logic [W-1:0] pin_s, pa_s, pb_s, rd_val;
  logic [H-1:0] hs_s;
  logic         we, we_dir, we_fsel, we_data, we_stat, we_ro;

  pport_sync #(.W(W)) u_sync_pin (.clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_s));
  pport_sync #(.W(W)) u_sync_pa  (.clk(clk), .rst_n(rst_n), .d(pa_in),  .q(pa_s));
  pport_sync #(.W(W)) u_sync_pb  (.clk(clk), .rst_n(rst_n), .d(pb_in),  .q(pb_s));
  pport_sync #(.W(H)) u_sync_hs  (.clk(clk), .rst_n(rst_n), .d(hs_in),  .q(hs_s));

  assign we      = sel & wr;
  assign we_dir  = we & (addr == A_DIR);
  assign we_fsel = we & (addr == A_FSEL);
  assign we_data = we & (addr == A_DATA);
  assign we_stat = we & (addr == A_STAT);
  assign we_ro   = we & ((addr == A_ALTA) | (addr == A_ALTB));

  always_comb begin
    dir_d   = we_dir  ? wdata : dir_q;
    fsel_d  = we_fsel ? wdata : fsel_q;
    latch_d = we_data ? wdata : latch_q;
    flag_d  = (flag_q & ~(we_stat ? wdata[H-1:0] : '0)) | stat_set;
    ack_d   = sel;
    rdata_d = (sel & ~wr) ? rd_val : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      fsel_q  <= '0;
      flag_q  <= '0;
      ack_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      dir_q   <= dir_d;
      fsel_q  <= fsel_d;
      flag_q  <= flag_d;
      ack_q   <= ack_d;
      rdata_q <= rdata_d;
    end
  end

  // output latch is intentionally outside the reset domain
  always_ff @(posedge clk) begin
    latch_q <= latch_d;
  end

  pport_rdmux #(.W(W)) u_rdmux (
    .addr(addr), .dir(dir_q), .fsel(fsel_q), .latch(latch_q),
    .pin_s(pin_s), .pa_s(pa_s), .pb_s(pb_s), .hs_s(hs_s),
    .flags(flag_q), .rd_val(rd_val)
  );

  pport_pinmux #(.W(W)) u_pinmux (
    .dir(dir_q), .fsel(fsel_q), .latch(latch_q),
    .alt_out(alt_out), .alt_oe(alt_oe),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  assign rdata = rdata_q;
  assign ack   = ack_q;

  a_r9_ack_follows_sel: assert property (@(posedge clk) disable iff (!rst_n)
    ack == $past(sel));

  a_r4_latch_load: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr && addr == A_DATA) |=> latch_q == $past(wdata));

  a_r6_input_undriven: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & ~dir_q) == '0);

  a_r6_port_drives: assert property (@(posedge clk) disable iff (!rst_n)
    ((dir_q & ~fsel_q) & ~pin_oe) == '0);

  a_r7_ro_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    we_ro |=> ($stable(dir_q) && $stable(fsel_q)));

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !we_stat |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
endmodule

// File: tb/pport_regs_test.sv
`timescale 1ns/1ps
module pport_regs_test;
  logic       clk = 1'b0;
  logic       rst_n, sel, wr;
  logic [2:0] addr;
  logic [7:0] wdata, rdata, pin_in, pin_out, pin_oe, alt_out, alt_oe, pa_in, pb_in;
  logic       ack;
  logic [3:0] hs_in, stat_set;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pport_regs uut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ack(ack), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .alt_out(alt_out), .alt_oe(alt_oe), .pa_in(pa_in), .pb_in(pb_in),
    .hs_in(hs_in), .stat_set(stat_set)
  );

  typedef struct packed {
    logic       w;
    logic [2:0] a;
    logic [7:0] d;
    logic [7:0] pins;
    logic [7:0] expv;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 3'd0, 8'hF0, 8'h00, 8'h00},  // dir upper outputs
    '{1'b1, 3'd2, 8'h5A, 8'h00, 8'h00},  // R4 latch
    '{1'b0, 3'd2, 8'h00, 8'h33, 8'h53},  // R2 R3 mixed view
    '{1'b1, 3'd1, 8'h0F, 8'h33, 8'h00},  // lower alternate
    '{1'b0, 3'd2, 8'h00, 8'hC6, 8'h56},  // R2 alternate inputs readable
    '{1'b1, 3'd2, 8'h81, 8'hC6, 8'h00},  // R4 with alternate set
    '{1'b0, 3'd2, 8'h00, 8'h00, 8'h80},  // R3
    '{1'b0, 3'd3, 8'h00, 8'h00, 8'hA5},  // R7 port A
    '{1'b0, 3'd4, 8'h00, 8'h00, 8'h3C},  // R7 port B
    '{1'b1, 3'd3, 8'hFF, 8'h00, 8'h00},  // R7 discarded write
    '{1'b0, 3'd0, 8'h00, 8'h00, 8'hF0},  // R7 dir unchanged
    '{1'b0, 3'd1, 8'h00, 8'h00, 8'h0F},  // R7 fsel unchanged
    '{1'b0, 3'd5, 8'h00, 8'h00, 8'hA0}   // R8 hs levels
  };

  task automatic chk(string req, logic [7:0] act, logic [7:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  // starts and ends just after a falling edge
  task automatic access(input logic w, input logic [2:0] a, input logic [7:0] d,
                        output logic [7:0] rd);
    sel = 1'b1; wr = w; addr = a; wdata = d;
    @(negedge clk);
    rd = rdata;
    chk("R9 ack", {7'd0, ack}, 8'h01);
    sel = 1'b0; wr = 1'b0;
  endtask

  logic [7:0] r;

  initial begin
    rst_n = 1'b0; sel = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
    pin_in = '0; alt_out = '0; alt_oe = '0; pa_in = 8'hA5; pb_in = 8'h3C;
    hs_in = 4'b1010; stat_set = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ack idle", {7'd0, ack}, 8'h00);
    access(1'b0, 3'd0, 8'h00, r); chk("R1 dir", r, 8'h00);
    access(1'b0, 3'd1, 8'h00, r); chk("R1 fsel", r, 8'h00);
    access(1'b0, 3'd5, 8'h00, r); chk("R1 flags", r & 8'h0F, 8'h00);
    @(negedge clk);
    chk("R9 ack low", {7'd0, ack}, 8'h00);
    chk("R9 rdata zero", rdata, 8'h00);

    for (int i = 0; i < NV; i++) begin
      pin_in = TBL[i].pins;
      repeat (3) @(negedge clk);
      access(TBL[i].w, TBL[i].a, TBL[i].d, r);
      if (!TBL[i].w) chk($sformatf("table row %0d", i), r, TBL[i].expv);
    end

    // R6 drive cases: dir F0, fsel 0F, latch 81
    alt_out = 8'hFF; alt_oe = 8'h05;
    @(negedge clk);
    chk("R6 oe port/input", pin_oe, 8'hF0);
    chk("R6 out", pin_out, 8'h8F);
    access(1'b1, 3'd0, 8'hFF, r);
    chk("R6 oe alternate", pin_oe, 8'hF5);
    // R6 forced transition on former alternate pins
    access(1'b1, 3'd1, 8'h00, r);
    access(1'b1, 3'd2, 8'h00, r);
    chk("R6 forced oe", pin_oe, 8'hFF);
    chk("R6 forced out", pin_out, 8'h00);
    access(1'b1, 3'd2, 8'h0F, r);
    chk("R6 forced toggle", pin_out, 8'h0F);

    // R5 latch across reset
    access(1'b1, 3'd2, 8'hC3, r);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 oe after reset", pin_oe, 8'h00);
    access(1'b1, 3'd0, 8'hFF, r);
    access(1'b0, 3'd2, 8'h00, r);
    chk("R5 latch kept", r, 8'hC3);
    access(1'b1, 3'd0, 8'h00, r);

    // R8 sticky flags
    stat_set = 4'b0101;
    @(negedge clk);
    stat_set = 4'b0000;
    repeat (2) @(negedge clk);
    access(1'b0, 3'd5, 8'h00, r); chk("R8 sticky", r, 8'hA5);
    access(1'b1, 3'd5, 8'h01, r);
    access(1'b0, 3'd5, 8'h00, r); chk("R8 clear", r, 8'hA4);
    stat_set = 4'b0100;
    access(1'b1, 3'd5, 8'h04, r);
    stat_set = 4'b0000;
    access(1'b0, 3'd5, 8'h00, r); chk("R8 set wins", r, 8'hA4);
    access(1'b0, 3'd7, 8'h00, r); chk("R9 unmapped", r, 8'h00);

    // R10 synchronizer latency, dir 0
    pin_in = 8'h00;
    repeat (3) @(negedge clk);
    pin_in = 8'h6E; sel = 1'b1; wr = 1'b0; addr = 3'd2;
    @(negedge clk); chk("R10 same cycle", rdata, 8'h00);
    @(negedge clk); chk("R10 one later", rdata, 8'h00);
    @(negedge clk); chk("R10 two later", rdata, 8'h6E);
    sel = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(100000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule